// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one indivisible read-modify-write on a byte of data memory selected by a pointer. Four operations are offered: swap, which stores the register operand; bit-set, which merges the operand into the byte with OR; bit-clear, which removes the operand's one-bits from the byte; and bit-toggle, which inverts the byte's bits wherever the operand has a one. In every case the caller gets back the byte exactly as it stood before the update. No condition flags are produced.

A request is presented for one cycle with an operation code, a pointer and an 8-bit operand. In that same cycle the unit drives the pointer onto the memory address and reads the byte combinationally. It places the updated byte on the write data and raises the memory write strobe, so the write lands on the closing rising edge and no other access can fall between the read and the write. The old byte is registered at that edge. In the following cycle it appears on the result port, with a one-cycle write-enable for the register file. Requests may arrive in consecutive cycles. A small two-state controller (IDLE, REPLY) sequences the result strobe. IDLE goes to REPLY on an accepted request. REPLY stays in REPLY on a further request and returns to IDLE when none arrives. IDLE stays in IDLE while no request is present.

Top module: `atomic_rmw_unit`

## Requirements
- R1: With req_op = 2'b00 (swap) and req_valid high, mem_wdata equals req_reg in that cycle.
- R2: With req_op = 2'b01 (bit-set), mem_wdata equals req_reg OR mem_rdata.
- R3: With req_op = 2'b10 (bit-clear), mem_wdata equals (NOT req_reg) AND mem_rdata.
- R4: With req_op = 2'b11 (bit-toggle), mem_wdata equals req_reg XOR mem_rdata.
- R5: In the cycle after an accepted request, rsp_data equals the memory byte at req_ptr as it was before that request's write. It keeps that value until the next request completes.
- R6: rsp_we is high for exactly the one cycle after each accepted request and is low otherwise.
- R7: mem_we is high exactly in cycles with req_valid high, and mem_addr then equals req_ptr. Bytes at other addresses are left unchanged.
- R8: Back-to-back requests to the same address see each other's result: the second returns the byte written by the first.
- R9: After reset, with no request, rsp_we is 0 and rsp_data is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per operation |
| req_op | input | 2 | Operation code: 00 swap, 01 set, 10 clear, 11 toggle |
| req_ptr | input | ADDR_W | Byte address taken from the pointer register |
| req_reg | input | DATA_W | Register operand |
| rsp_data | output | DATA_W | Original memory byte returned to the register |
| rsp_we | output | 1 | Register write enable, one cycle per operation |
| mem_addr | output | ADDR_W | Memory address |
| mem_rdata | input | DATA_W | Combinational read data from memory |
| mem_wdata | output | DATA_W | Updated byte to write |
| mem_we | output | 1 | Memory write strobe, taken on the rising edge |

## Verification
The bench sweeps every operation against all 256 operand values and sixteen memory byte patterns, including all-zeros and all-ones. An inverted operand in bit-clear, or a swapped set/toggle mapping, would leave a wrong byte in memory. It chains requests to one address with no gap between them. A design that returned a stale byte, or registered the write a cycle late, would hand the second request the wrong value. Idle cycles between requests catch a result strobe that lingers, a stray memory write, and a result register that fails to hold. The sweep also watches a neighbouring address for writes that land at the wrong location.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [1:0] {
        OP_SWAP = 2'b00,
        OP_SET  = 2'b01,
        OP_CLR  = 2'b10,
        OP_TGL  = 2'b11
    } rmw_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } rmw_state_e;

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rmw_op_e             op,
    input  logic [DATA_W-1:0]   operand,
    input  logic [DATA_W-1:0]   old_byte,
    output logic [DATA_W-1:0]   new_byte
);

    // Per-bit evaluation; each lane is independent of its neighbours.
    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        always_comb begin
            unique case (op)
                OP_SWAP: new_byte[b] = operand[b];
                OP_SET:  new_byte[b] = operand[b] | old_byte[b];
                OP_CLR:  new_byte[b] = ~operand[b] & old_byte[b];
                OP_TGL:  new_byte[b] = operand[b] ^ old_byte[b];
                default: new_byte[b] = old_byte[b];
            endcase
        end
    end

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import rmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic reply_we
);

    rmw_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = accept ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = accept ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_REPLY: reply_we = 1'b1;
            default:  reply_we = 1'b0;
        endcase
    end

    // R6: the result strobe follows each accepted request by exactly one cycle
    a_r6_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> reply_we);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !reply_we);

endmodule

// File: rtl/rmw_reply.sv
module rmw_reply #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] old_byte,
    output logic [DATA_W-1:0] held
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       held <= '0;
        else if (capture) held <= old_byte;
    end

    // R5: without a capture the returned byte is held
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(held));

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_ptr,
    input  logic [DATA_W-1:0] req_reg,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);

    rmw_op_e op_sel;

    assign op_sel   = rmw_op_e'(req_op);
    assign mem_addr = req_ptr;
    assign mem_we   = req_valid;

    rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (op_sel),
        .operand  (req_reg),
        .old_byte (mem_rdata),
        .new_byte (mem_wdata)
    );

    rmw_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (req_valid),
        .reply_we (rsp_we)
    );

    rmw_reply #(.DATA_W(DATA_W)) u_reply (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (req_valid),
        .old_byte (mem_rdata),
        .held     (rsp_data)
    );

    // R1: swap stores the operand
    a_r1_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00) |-> (mem_wdata == req_reg));
    // R2: every one-bit of operand and old byte survives, nothing else appears
    a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01) |->
        (((mem_wdata & req_reg) == req_reg) && ((mem_wdata & mem_rdata) == mem_rdata)
         && ((mem_wdata & ~(req_reg | mem_rdata)) == '0)));
    // R3: cleared bits gone, others unchanged
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10) |->
        (((mem_wdata & req_reg) == '0) && ((mem_wdata | req_reg) == (mem_rdata | req_reg))));
    // R4: difference between old and new byte is the operand
    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |-> ((mem_wdata ^ mem_rdata) == req_reg));
    // R5: returned byte is the pre-write value
    a_r5_old_byte: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_we |-> (rsp_data == $past(mem_rdata)));
    // R7: memory access targets the pointer and only on requests
    a_r7_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == req_ptr));
    a_r7_idle_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !mem_we);

endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;

    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_ptr = '0;
    logic [DW-1:0] req_reg = '0;
    logic [DW-1:0] rsp_data;
    logic          rsp_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;

    logic [DW-1:0] mem [1<<AW];

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    atomic_rmw_unit #(.ADDR_W(AW), .DATA_W(DW)) u_atomic_rmw_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_ptr(req_ptr), .req_reg(req_reg), .rsp_data(rsp_data),
        .rsp_we(rsp_we), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    function automatic logic [DW-1:0] model(input logic [1:0] op,
                                            input logic [DW-1:0] r,
                                            input logic [DW-1:0] m);
        case (op)
            2'b00:   return r;
            2'b01:   return r | m;
            2'b10:   return m & (8'hFF - r);
            default: return r ^ m;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge; result and memory are checked after the rising edge.
    task automatic do_op(input logic [1:0] op, input logic [AW-1:0] p, input logic [DW-1:0] r);
        logic [DW-1:0] old_b, exp_b, nb_before;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_ptr = p; req_reg = r;
        old_b = mem[p];
        exp_b = model(op, r, old_b);
        nb_before = mem[p ^ 1];
        @(posedge clk); #1;
        case (op)
            2'b00: check(mem[p] == exp_b, "R1 swap", mem[p], exp_b);
            2'b01: check(mem[p] == exp_b, "R2 set", mem[p], exp_b);
            2'b10: check(mem[p] == exp_b, "R3 clear", mem[p], exp_b);
            default: check(mem[p] == exp_b, "R4 toggle", mem[p], exp_b);
        endcase
        check(rsp_data == old_b, "R5 old byte", rsp_data, old_b);
        check(rsp_we == 1'b1, "R6 strobe", rsp_we, 1);
        check(mem[p ^ 1] == nb_before, "R7 neighbour", mem[p ^ 1], nb_before);
    endtask

    task automatic idle_cycle();
        logic [DW-1:0] held;
        @(negedge clk);
        req_valid = 1'b0;
        held = rsp_data;
        check(mem_we == 1'b0, "R7 no write when idle", mem_we, 0);
        @(posedge clk); #1;
        check(rsp_we == 1'b0, "R6 strobe drops", rsp_we, 0);
        check(rsp_data == held, "R5 hold", rsp_data, held);
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) mem[i] = 8'(i * 29 + 3);
        repeat (3) @(posedge clk);
        #1;
        check(rsp_we == 1'b0, "R9 reset strobe", rsp_we, 0);
        check(rsp_data == 8'h00, "R9 reset data", rsp_data, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(rsp_we == 1'b0, "R9 idle after reset", rsp_we, 0);
        check(rsp_data == 8'h00, "R9 data after reset", rsp_data, 0);

        // R8: chained requests at one address
        @(negedge clk); mem[5] = 8'h0F;
        do_op(2'b01, 4'd5, 8'hF0);
        do_op(2'b10, 4'd5, 8'h3C);
        check(rsp_data == 8'hFF, "R8 chain set->clear", rsp_data, 8'hFF);
        do_op(2'b11, 4'd5, 8'hFF);
        check(rsp_data == 8'hC3, "R8 chain clear->toggle", rsp_data, 8'hC3);
        do_op(2'b00, 4'd5, 8'hA5);
        check(rsp_data == 8'h3C, "R8 chain toggle->swap", rsp_data, 8'h3C);
        idle_cycle();
        check(mem[5] == 8'hA5, "R8 final byte", mem[5], 8'hA5);

        // Sweep R1..R4 over operands and memory patterns
        for (int op = 0; op < 4; op++) begin
            for (int k = 0; k < 16; k++) begin
                logic [DW-1:0] pat;
                pat = (k == 0) ? 8'h00 : (k == 15) ? 8'hFF : 8'(k * 37 + 11);
                for (int r = 0; r < 256; r++) begin
                    @(negedge clk);
                    mem[r % 16] = pat;
                    do_op(2'(op), 4'(r % 16), 8'(r));
                    if (r % 64 == 63) idle_cycle();
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule